// File: doc/BRIEF.md
# Tagged Fully-Associative Translation Cache

This block keeps a small set of recently used virtual-to-physical translations so that most memory accesses skip the multi-access table walk. A lookup presents a virtual page number (address bits 47:12), the current address-space tag and the kind of access. Within the same cycle the block answers with a hit, the physical frame, the page size and the stored permissions. If no entry matches, it raises a walk request. The external walker later writes the finished translation back through the fill port.

Each entry carries a 12-bit address-space tag, so translations from several processes can stay resident across a context switch. Entries for 4 KB pages and 2 MB pages share one array. Several invalidation paths are provided:
- a flush of every entry;
- a flush of one tag, which spares entries marked global;
- an invalidate-everything on a new root table base, which applies only while tagging is off.

Top module: `tlb_fa_tagged`

## Requirements
- R1: After reset every entry is invalid. Any valid lookup then gives lk_hit=0, lk_fault=0 and walk_req=1. walk_req is high only for a valid lookup that matches no entry.
- R2: With 64 entries (ENTRIES), the outputs of a lookup depend combinationally on the lookup inputs, so the result appears in the same cycle. A fill written at a clock edge is visible to lookups from the next cycle onward. On a hit of a 4 KB entry, hit_pfn equals the stored frame. When lk_hit=0, hit_pfn and the hit_* flags are zero.
- R3: A non-global entry matches only a lookup whose lk_tag equals the entry's tag.
- R4: An entry filled with fill_global=1 matches a lookup under any tag.
- R5: A 2 MB entry (fill_huge=1) compares only VPN bits 35:9, which are address bits 47:21. On a hit, hit_huge=1 and hit_pfn is the stored frame with its low 9 bits replaced by lk_vpn[8:0]. A 4 KB entry compares all 36 VPN bits.
- R6: A matching lookup becomes a fault in any of these cases:
  - lk_write=1 and the entry is not writable;
  - lk_user=1 and the entry is supervisor-only;
  - lk_exec=1 and the entry is no-execute.
  A fault gives lk_fault=1, lk_hit=0 and walk_req=0.
- R7: flush_all invalidates every entry at the clock edge. Every lookup in the next cycle misses.
- R8: flush_tag_valid invalidates, in one cycle, every non-global entry whose tag equals flush_tag. Global entries and entries with other tags stay.
- R9: root_load with tag_en=0 invalidates every entry. root_load with tag_en=1 has no effect on the contents.
- R10: A fill whose VPN (masked by its page size), page size and tag equal those of a valid entry overwrites that entry. No second copy is made and no other entry is evicted.
- R11: A fill that matches no entry takes the lowest-numbered invalid entry. When all entries are valid it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R12: A fill in a cycle where flush_all, flush_tag_valid or an untagged root_load is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | Address-space tagging enabled |
| root_load | input | 1 | New root table base loaded |
| flush_all | input | 1 | Invalidate all entries |
| flush_tag_valid | input | 1 | Invalidate non-global entries of one tag |
| flush_tag | input | 12 | Tag to invalidate |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 36 | Lookup virtual page number (address bits 47:12) |
| lk_tag | input | 12 | Current address-space tag |
| lk_write | input | 1 | Access is a write |
| lk_exec | input | 1 | Access is an instruction fetch |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation hit with permission granted |
| lk_fault | output | 1 | Entry matched but permission denied |
| walk_req | output | 1 | Miss: request a table walk |
| hit_pfn | output | 40 | Physical frame number (4 KB granule) |
| hit_huge | output | 1 | Hit entry maps 2 MB |
| hit_wr | output | 1 | Hit entry writable |
| hit_user | output | 1 | Hit entry user-accessible |
| hit_nx | output | 1 | Hit entry no-execute |
| fill_valid | input | 1 | Write a completed translation |
| fill_vpn | input | 36 | Fill virtual page number |
| fill_tag | input | 12 | Fill address-space tag |
| fill_pfn | input | 40 | Fill physical frame number |
| fill_huge | input | 1 | Fill maps 2 MB |
| fill_global | input | 1 | Fill matches all tags |
| fill_wr | input | 1 | Fill writable |
| fill_user | input | 1 | Fill user-accessible |
| fill_nx | input | 1 | Fill no-execute |

## Verification
The bench fills all 64 entries and then adds two more to confirm which entries are evicted. A wrong victim choice would drop a recently filled translation instead of the oldest one. It refills a resident page with a new frame and then checks that every other entry still hits. A design that duplicated the page would report the stale frame or evict a bystander.

It probes a 2 MB entry just inside and just outside its range, and checks that the low frame bits come from the request. It confirms that a flush by tag spares global entries and other tags, and that root_load changes nothing while tagging is on. Long random runs over a small page space, compared against a bench model, stress replacement together with the flushes.

// File: rtl/tlb_fa_tagged.sv
module tlb_fa_tagged #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int TAG_W   = 12,
  parameter int HUGE_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_en,
  input  logic             root_load,
  input  logic             flush_all,
  input  logic             flush_tag_valid,
  input  logic [TAG_W-1:0] flush_tag,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_write,
  input  logic             lk_exec,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic             walk_req,
  output logic [PFN_W-1:0] hit_pfn,
  output logic             hit_huge,
  output logic             hit_wr,
  output logic             hit_user,
  output logic             hit_nx,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_huge,
  input  logic             fill_global,
  input  logic             fill_wr,
  input  logic             fill_user,
  input  logic             fill_nx
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] v_q, g_q, h_q, w_q, u_q, nx_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic             m_any, fm_any, free_any, viol;
  logic [IDX_W-1:0] sel, fm_idx, free_idx, widx;

  wire wipe_all  = flush_all | (root_load & ~tag_en);
  wire any_flush = wipe_all | flush_tag_valid;
  wire do_fill   = fill_valid & ~any_flush;
  wire use_rr    = ~fm_any & ~free_any;

  always_comb begin
    m_any = 1'b0; sel = '0;
    fm_any = 1'b0; fm_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v_q[i] && (g_q[i] || tag_q[i] == lk_tag) &&
          (h_q[i] ? vpn_q[i][VPN_W-1:HUGE_W] == lk_vpn[VPN_W-1:HUGE_W]
                  : vpn_q[i] == lk_vpn)) begin
        m_any = 1'b1; sel = IDX_W'(i);
      end
      if (v_q[i] && h_q[i] == fill_huge && tag_q[i] == fill_tag &&
          (fill_huge ? vpn_q[i][VPN_W-1:HUGE_W] == fill_vpn[VPN_W-1:HUGE_W]
                     : vpn_q[i] == fill_vpn)) begin
        fm_any = 1'b1; fm_idx = IDX_W'(i);
      end
      if (!v_q[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
  end

  assign widx = fm_any ? fm_idx : (free_any ? free_idx : rr_q);

  assign viol     = (lk_write & ~w_q[sel]) | (lk_exec & nx_q[sel]) | (lk_user & ~u_q[sel]);
  assign lk_hit   = lk_valid & m_any & ~viol;
  assign lk_fault = lk_valid & m_any & viol;
  assign walk_req = lk_valid & ~m_any;
  assign hit_huge = lk_hit & h_q[sel];
  assign hit_wr   = lk_hit & w_q[sel];
  assign hit_user = lk_hit & u_q[sel];
  assign hit_nx   = lk_hit & nx_q[sel];
  assign hit_pfn  = !lk_hit ? '0 :
                    h_q[sel] ? {pfn_q[sel][PFN_W-1:HUGE_W], lk_vpn[HUGE_W-1:0]} : pfn_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (wipe_all) begin
      v_q <= '0;
    end else if (flush_tag_valid) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!g_q[i] && tag_q[i] == flush_tag) v_q[i] <= 1'b0;
    end else if (fill_valid) begin
      v_q[widx] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[widx] <= fill_vpn;
      tag_q[widx] <= fill_tag;
      pfn_q[widx] <= fill_pfn;
      g_q[widx]   <= fill_global;
      h_q[widx]   <= fill_huge;
      w_q[widx]   <= fill_wr;
      u_q[widx]   <= fill_user;
      nx_q[widx]  <= fill_nx;
    end
  end
endmodule

module tlb_fa_tagged_chk #(
  parameter int VPN_W  = 36,
  parameter int PFN_W  = 40,
  parameter int HUGE_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tag_en,
  input logic             root_load,
  input logic             flush_all,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_write,
  input logic             lk_exec,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             walk_req,
  input logic [PFN_W-1:0] hit_pfn,
  input logic             hit_huge,
  input logic             hit_wr,
  input logic             hit_nx
);
  a_r6_hit_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));
  a_r1_walk_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> lk_valid && !lk_hit && !lk_fault);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit && !lk_fault);
  a_r9_untagged_root_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (root_load && !tag_en) |=> !lk_hit && !lk_fault);
  a_r6_write_needs_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> hit_wr);
  a_r6_exec_needs_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_exec) |-> !hit_nx);
  a_r5_huge_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && hit_huge) |-> hit_pfn[HUGE_W-1:0] == lk_vpn[HUGE_W-1:0]);
endmodule

bind tlb_fa_tagged tlb_fa_tagged_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .HUGE_W(HUGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .root_load(root_load), .flush_all(flush_all),
  .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_exec(lk_exec),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .walk_req(walk_req), .hit_pfn(hit_pfn),
  .hit_huge(hit_huge), .hit_wr(hit_wr), .hit_nx(hit_nx));

// File: tb/tlb_fa_tagged_tb.sv
`timescale 1ns/1ps
module tlb_fa_tagged_tb_top;
  localparam int N = 64;

  logic clk = 0, rst_n = 0;
  logic tag_en = 0, root_load = 0, flush_all = 0, flush_tag_valid = 0;
  logic [11:0] flush_tag = 0;
  logic lk_valid = 0, lk_write = 0, lk_exec = 0, lk_user = 0;
  logic [35:0] lk_vpn = 0;
  logic [11:0] lk_tag = 0;
  logic lk_hit, lk_fault, walk_req, hit_huge, hit_wr, hit_user, hit_nx;
  logic [39:0] hit_pfn;
  logic fill_valid = 0, fill_huge = 0, fill_global = 0, fill_wr = 0, fill_user = 0, fill_nx = 0;
  logic [35:0] fill_vpn = 0;
  logic [11:0] fill_tag = 0;
  logic [39:0] fill_pfn = 0;

  always #2.5 clk = ~clk;

  tlb_fa_tagged dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  bit m_v[N], m_g[N], m_h[N], m_w[N], m_u[N], m_nx[N];
  logic [35:0] m_vpn[N];
  logic [11:0] m_tag[N];
  logic [39:0] m_pfn[N];
  int m_rr = 0;

  bit r_hit, r_fault, r_walk, r_huge;
  logic [39:0] r_pfn;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit same_pg(input bit h, input logic [35:0] a, input logic [35:0] b);
    return h ? (a[35:9] == b[35:9]) : (a == b);
  endfunction

  function automatic void m_fill(input logic [35:0] v, input logic [11:0] t, input logic [39:0] p,
                                 input bit h, input bit g, input bit w, input bit u, input bit nx);
    int idx = -1;
    for (int i = 0; i < N; i++)
      if (idx < 0 && m_v[i] && m_h[i] == h && m_tag[i] == t && same_pg(h, m_vpn[i], v)) idx = i;
    for (int i = 0; i < N; i++)
      if (idx < 0 && !m_v[i]) idx = i;
    if (idx < 0) begin
      idx = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[idx] = 1; m_vpn[idx] = v; m_tag[idx] = t; m_pfn[idx] = p;
    m_h[idx] = h; m_g[idx] = g; m_w[idx] = w; m_u[idx] = u; m_nx[idx] = nx;
  endfunction

  function automatic void m_look(input logic [35:0] v, input logic [11:0] t, input bit w, input bit x,
                                 input bit u, output bit eh, output bit ef, output bit ew,
                                 output logic [39:0] ep);
    int s = -1;
    for (int i = 0; i < N; i++)
      if (s < 0 && m_v[i] && (m_g[i] || m_tag[i] == t) && same_pg(m_h[i], m_vpn[i], v)) s = i;
    eh = 0; ef = 0; ew = (s < 0); ep = '0;
    if (s >= 0) begin
      if ((w && !m_w[s]) || (x && m_nx[s]) || (u && !m_u[s])) ef = 1;
      else begin
        eh = 1;
        ep = m_h[s] ? {m_pfn[s][39:9], v[8:0]} : m_pfn[s];
      end
    end
  endfunction

  task automatic look(input logic [35:0] v, input logic [11:0] t,
                      input bit w = 0, input bit x = 0, input bit u = 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_tag = t; lk_write = w; lk_exec = x; lk_user = u;
    #1;
    r_hit = lk_hit; r_fault = lk_fault; r_walk = walk_req; r_pfn = hit_pfn; r_huge = hit_huge;
  endtask

  task automatic fill(input logic [35:0] v, input logic [11:0] t, input logic [39:0] p,
                      input bit h = 0, input bit g = 0, input bit w = 1, input bit u = 1,
                      input bit nx = 0, input bit with_flush = 0);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_tag = t; fill_pfn = p; fill_huge = h;
    fill_global = g; fill_wr = w; fill_user = u; fill_nx = nx; flush_all = with_flush;
    @(posedge clk); #1;
    fill_valid = 0; flush_all = 0;
    if (with_flush) for (int i = 0; i < N; i++) m_v[i] = 0;
    else m_fill(v, t, p, h, g, w, u, nx);
  endtask

  task automatic do_flush_all();
    @(negedge clk); flush_all = 1;
    @(posedge clk); #1; flush_all = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic do_flush_tag(input logic [11:0] t);
    @(negedge clk); flush_tag_valid = 1; flush_tag = t;
    @(posedge clk); #1; flush_tag_valid = 0;
    for (int i = 0; i < N; i++) if (!m_g[i] && m_tag[i] == t) m_v[i] = 0;
  endtask

  task automatic do_root(input bit te);
    @(negedge clk); root_load = 1; tag_en = te;
    @(posedge clk); #1; root_load = 0;
    if (!te) for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hits;
    bit eh, ef, ew;
    logic [39:0] ep;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    look(36'h100, 12'd5);
    chk("R1 reset miss walk", {r_hit, r_fault, r_walk}, 3'b001);

    for (int k = 0; k < N; k++) fill(36'h100 + k, 12'd5, 40'h1000 + k);
    hits = 0;
    for (int k = 0; k < N; k++) begin
      look(36'h100 + k, 12'd5);
      if (r_hit && r_pfn == 40'h1000 + k) hits++;
    end
    chk("R2 all 64 filled entries hit", hits, N);
    fill(36'h200, 12'd5, 40'h2000);
    look(36'h100, 12'd5);
    chk("R11 first victim is entry 0", r_walk, 1);
    look(36'h101, 12'd5);
    chk("R11 entry 1 kept", r_hit, 1);
    look(36'h200, 12'd5);
    chk("R2 new fill hits", r_pfn, 40'h2000);
    fill(36'h201, 12'd5, 40'h2001);
    look(36'h101, 12'd5);
    chk("R11 pointer advanced to entry 1", r_walk, 1);

    fill(36'h105, 12'd5, 40'hABC);
    look(36'h105, 12'd5);
    chk("R10 refill overwrites frame", r_pfn, 40'hABC);
    hits = 0;
    for (int k = 2; k < N; k++) begin
      look(36'h100 + k, 12'd5);
      if (r_hit) hits++;
    end
    chk("R10 refill evicts nothing", hits, N - 2);

    do_flush_all();
    look(36'h110, 12'd5);
    chk("R7 flush_all clears", {r_hit, r_walk}, 2'b01);

    fill(36'h300, 12'd1, 40'h3000);
    look(36'h300, 12'd2);
    chk("R3 other tag misses", {r_hit, r_walk}, 2'b01);
    look(36'h300, 12'd1);
    chk("R3 own tag hits", r_hit, 1);
    fill(36'h301, 12'd1, 40'h3010, 0, 1);
    look(36'h301, 12'd7);
    chk("R4 global hits any tag", {r_hit, r_pfn}, {1'b1, 40'h3010});
    fill(36'h302, 12'd3, 40'h3020);
    do_flush_tag(12'd1);
    look(36'h300, 12'd1);
    chk("R8 tagged entry flushed", r_walk, 1);
    look(36'h301, 12'd1);
    chk("R8 global survives", r_hit, 1);
    look(36'h302, 12'd3);
    chk("R8 other tag survives", r_hit, 1);

    fill(36'hABC00, 12'd4, 40'h77E00, 1);
    look(36'hABC1F, 12'd4);
    chk("R5 huge hit offset", {r_hit, r_huge, r_pfn}, {2'b11, 40'h77E1F});
    look(36'hABDFF, 12'd4);
    chk("R5 huge top of range", r_pfn, 40'h77FFF);
    look(36'hABE00, 12'd4);
    chk("R5 outside huge misses", r_walk, 1);

    fill(36'h400, 12'd1, 40'h4000, 0, 0, 0, 0, 1);
    look(36'h400, 12'd1);
    chk("R6 supervisor read hits", r_hit, 1);
    look(36'h400, 12'd1, 1);
    chk("R6 write fault", {r_hit, r_fault, r_walk}, 3'b010);
    look(36'h400, 12'd1, 0, 0, 1);
    chk("R6 user fault", {r_hit, r_fault, r_walk}, 3'b010);
    look(36'h400, 12'd1, 0, 1);
    chk("R6 exec fault", {r_hit, r_fault, r_walk}, 3'b010);

    do_root(1);
    look(36'h400, 12'd1);
    chk("R9 tagged root load keeps entries", r_hit, 1);
    do_root(0);
    look(36'h400, 12'd1);
    chk("R9 untagged root load clears", r_walk, 1);

    fill(36'h500, 12'd1, 40'h5000, 0, 0, 1, 1, 0, 1);
    look(36'h500, 12'd1);
    chk("R12 fill dropped under flush", r_walk, 1);

    for (int it = 0; it < 4000; it++) begin
      int op = $urandom_range(0, 99);
      logic [35:0] v = 36'($urandom_range(0, 99));
      logic [11:0] t = 12'($urandom_range(0, 3));
      if (op < 40) fill(v, t, 40'($urandom), 0, $urandom_range(0, 9) == 0,
                        1'($urandom), 1'($urandom), 1'($urandom));
      else if (op < 96) begin
        bit w = 1'($urandom), x = 1'($urandom), u = 1'($urandom);
        look(v, t, w, x, u);
        m_look(v, t, w, x, u, eh, ef, ew, ep);
        chk("R11 random vs model", {r_hit, r_fault, r_walk, r_pfn}, {eh, ef, ew, ep});
      end
      else if (op < 99) do_flush_tag(t);
      else do_flush_all();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule